// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts hardware activity for profiling. It holds one free-running cycle counter and a small bank of event counters, each 32 bits wide and wrapping to zero on overflow. Every event counter watches one line of an event strobe vector. The line is picked by an event number that software programs. A counter advances by one on each clock where its strobe is high, provided three conditions hold: the unit is globally enabled, the counter's own enable bit is set, and the programmed event number is marked as implemented in a build-time support bitmap.

Software reaches the unit through a single-cycle register bus. A request is a pulse on `bus_req` with address, write flag, write data and a privilege flag. Read data is returned combinationally in the same cycle. There is no back-pressure: every access completes in the cycle it is presented. The event type and the count of one event counter are reached through two windowed registers. A select register decides which counter those windows address. A user-access bit decides whether unprivileged requests reach the registers at all.

Register word addresses on `bus_addr`: 0 control, 1 counter enables, 2 counter select, 3 windowed event type, 4 windowed event count, 5 cycle count (read-only), 6 support bitmap (read-only), 7 user access. In the control register, bit 0 is the global enable, bit 1 clears the cycle counter and bit 2 clears all event counters.

Top module: `perf_monitor_unit`

## Requirements
- R1: After reset every register and counter reads zero. While control bit 0 is clear, no counter changes except through a clear or a software write.
- R2: While control bit 0 is set, the cycle count (address 5) rises by one on each clock. Writes to address 5 are ignored.
- R3: Writing 1 to control bit 1 zeroes the cycle counter, and writing 1 to bit 2 zeroes all event counters, at the same clock edge as the write. A clear wins over an increment at that edge. Bits 1 and 2 always read as zero.
- R4: The select register (address 2) picks which counter the event-type window (address 3) reads and writes. Each counter keeps its own 5-bit event number, and the number is reset to 0.
- R5: The count window (address 4) reads and writes the selected counter's 32-bit value. A counter at 0xFFFFFFFF that takes one event becomes 0.
- R6: The support bitmap (address 6) is read-only, with a default of 0xFFFFFF7F, so event 7 is not implemented. A counter programmed with an unimplemented event number never increments.
- R7: While the user-access bit is clear, unprivileged writes are ignored and unprivileged reads return zero. While it is set, unprivileged accesses behave like privileged ones.
- R8: Only privileged writes change the user-access bit (address 7, bit 0). Unprivileged writes to it are always ignored.
- R9: A select value of 4 or more makes both windows read zero and ignore writes. The select value itself still reads back.
- R10: Bit i of the counter-enable register (address 1) gates event counter i. A counter advances at most one per clock.
- R11: The global enable, counter enables, select and event numbers read back the values written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Access comes from privileged software |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read request |
| event_strobe | input | 32 | One strobe line per event number |

## Verification
A wrong counter state shows up on the very next read of the cycle or count window. So the bench holds strobes high for a known number of edges and compares exact totals. A corrupted select or event number shows as a wrong window readback, or as a counter that moves when it should stay frozen. This is visible one access after the faulty write. Gating faults in the access path show in the same cycle: an unprivileged read returns nonzero data, or a supposedly ignored write turns up on a privileged read-back.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNTEN   = 3'd1;
  localparam logic [ADDR_W-1:0] A_SEL     = 3'd2;
  localparam logic [ADDR_W-1:0] A_TYPE    = 3'd3;
  localparam logic [ADDR_W-1:0] A_VALUE   = 3'd4;
  localparam logic [ADDR_W-1:0] A_CYCLE   = 3'd5;
  localparam logic [ADDR_W-1:0] A_SUPPORT = 3'd6;
  localparam logic [ADDR_W-1:0] A_USER    = 3'd7;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_CCLR_BIT = 1;
  localparam int CTRL_ECLR_BIT = 2;
endpackage

// File: rtl/pmu_reg_file.sv
module pmu_reg_file
  import pmu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_CNT = 4,
  parameter int NUM_EVT = 32,
  parameter int EVT_W = 5,
  parameter int SEL_W = 5,
  parameter logic [NUM_EVT-1:0] SUPPORT_MAP = '1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             bus_req,
  input  logic                             bus_we,
  input  logic                             bus_priv,
  input  logic [ADDR_W-1:0]                bus_addr,
  input  logic [DATA_W-1:0]                bus_wdata,
  output logic [DATA_W-1:0]                bus_rdata,
  input  logic [DATA_W-1:0]                cyc_val,
  input  logic [NUM_CNT-1:0][DATA_W-1:0]   evt_val,
  output logic                             glob_en,
  output logic                             user_en,
  output logic [NUM_CNT-1:0]               cnt_en,
  output logic [NUM_CNT-1:0][EVT_W-1:0]    evt_type,
  output logic                             clr_cyc,
  output logic                             clr_evt,
  output logic [NUM_CNT-1:0]               cnt_wr,
  output logic [DATA_W-1:0]                wr_data
);
  logic [SEL_W-1:0] sel_q;
  logic access_ok, wr_ok, rd_ok, sel_in_rng;
  logic [EVT_W-1:0]  win_type;
  logic [DATA_W-1:0] win_val, rd_mux;

  assign access_ok  = bus_req && (bus_priv || user_en);
  assign wr_ok      = access_ok && bus_we;
  assign rd_ok      = access_ok && !bus_we;
  assign sel_in_rng = ({1'b0, sel_q} < (SEL_W+1)'(NUM_CNT));
  assign clr_cyc    = wr_ok && (bus_addr == A_CTRL) && bus_wdata[CTRL_CCLR_BIT];
  assign clr_evt    = wr_ok && (bus_addr == A_CTRL) && bus_wdata[CTRL_ECLR_BIT];
  assign wr_data    = bus_wdata;

  generate
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_wr
      assign cnt_wr[g] = wr_ok && (bus_addr == A_VALUE) && (sel_q == SEL_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glob_en  <= 1'b0;
      user_en  <= 1'b0;
      cnt_en   <= '0;
      sel_q    <= '0;
      evt_type <= '0;
    end else if (wr_ok) begin
      case (bus_addr)
        A_CTRL:  glob_en <= bus_wdata[CTRL_EN_BIT];
        A_CNTEN: cnt_en  <= bus_wdata[NUM_CNT-1:0];
        A_SEL:   sel_q   <= bus_wdata[SEL_W-1:0];
        A_TYPE: begin
          for (int i = 0; i < NUM_CNT; i++)
            if (sel_q == SEL_W'(i)) evt_type[i] <= bus_wdata[EVT_W-1:0];
        end
        A_USER:  if (bus_priv) user_en <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    win_type = '0;
    win_val  = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (sel_q == SEL_W'(i)) begin
        win_type = evt_type[i];
        win_val  = evt_val[i];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CTRL:    rd_mux = DATA_W'(glob_en);
      A_CNTEN:   rd_mux = DATA_W'(cnt_en);
      A_SEL:     rd_mux = DATA_W'(sel_q);
      A_TYPE:    rd_mux = sel_in_rng ? DATA_W'(win_type) : '0;
      A_VALUE:   rd_mux = sel_in_rng ? win_val : '0;
      A_CYCLE:   rd_mux = cyc_val;
      A_SUPPORT: rd_mux = DATA_W'(SUPPORT_MAP);
      A_USER:    rd_mux = DATA_W'(user_en);
      default:   rd_mux = '0;
    endcase
  end

  assign bus_rdata = rd_ok ? rd_mux : '0;
endmodule

// File: rtl/pmu_event_counter.sv
module pmu_event_counter #(
  parameter int DATA_W = 32,
  parameter int NUM_EVT = 32,
  parameter int EVT_W = 5,
  parameter logic [NUM_EVT-1:0] SUPPORT_MAP = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               glob_en,
  input  logic               cnt_en,
  input  logic [EVT_W-1:0]   evt_sel,
  input  logic [NUM_EVT-1:0] event_strobe,
  input  logic               clr,
  input  logic               wr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  count
);
  logic evt_valid, hit;

  assign evt_valid = ({1'b0, evt_sel} < (EVT_W+1)'(NUM_EVT));
  assign hit = glob_en && cnt_en && evt_valid &&
               SUPPORT_MAP[evt_sel] && event_strobe[evt_sel];

  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (wr)  count <= wdata;
    else if (hit) count <= count + DATA_W'(1);
  end
endmodule

// File: rtl/pmu_cycle_counter.sv
module pmu_cycle_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              clr,
  output logic [DATA_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (en)  count <= count + DATA_W'(1);
  end
endmodule

// File: rtl/perf_monitor_unit.sv
module perf_monitor_unit
  import pmu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_CNT = 4,
  parameter int NUM_EVT = 32,
  parameter int SEL_W = 5,
  parameter logic [NUM_EVT-1:0] SUPPORT_MAP = 32'hFFFF_FF7F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic               bus_priv,
  input  logic [2:0]         bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_EVT-1:0] event_strobe
);
  localparam int EVT_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic glob_en, user_en, clr_cyc, clr_evt;
  logic [NUM_CNT-1:0]             cnt_en, cnt_wr;
  logic [NUM_CNT-1:0][EVT_W-1:0]  evt_type;
  logic [NUM_CNT-1:0][DATA_W-1:0] evt_val;
  logic [DATA_W-1:0]              cyc_val, wr_data;

  pmu_reg_file #(
    .DATA_W(DATA_W), .NUM_CNT(NUM_CNT), .NUM_EVT(NUM_EVT),
    .EVT_W(EVT_W), .SEL_W(SEL_W), .SUPPORT_MAP(SUPPORT_MAP)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_priv(bus_priv), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cyc_val(cyc_val), .evt_val(evt_val),
    .glob_en(glob_en), .user_en(user_en), .cnt_en(cnt_en),
    .evt_type(evt_type), .clr_cyc(clr_cyc), .clr_evt(clr_evt),
    .cnt_wr(cnt_wr), .wr_data(wr_data)
  );

  pmu_cycle_counter #(.DATA_W(DATA_W)) u_cyc (
    .clk(clk), .rst_n(rst_n), .en(glob_en), .clr(clr_cyc), .count(cyc_val)
  );

  generate
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
      pmu_event_counter #(
        .DATA_W(DATA_W), .NUM_EVT(NUM_EVT), .EVT_W(EVT_W),
        .SUPPORT_MAP(SUPPORT_MAP)
      ) u_evt (
        .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .cnt_en(cnt_en[g]),
        .evt_sel(evt_type[g]), .event_strobe(event_strobe),
        .clr(clr_evt), .wr(cnt_wr[g]), .wdata(wr_data), .count(evt_val[g])
      );
    end
  endgenerate
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
  parameter int DATA_W = 32,
  parameter int NUM_CNT = 4,
  parameter int NUM_EVT = 32,
  parameter int EVT_W = 5,
  parameter logic [NUM_EVT-1:0] SUPPORT_MAP = '1
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             bus_req,
  input logic                             bus_we,
  input logic                             bus_priv,
  input logic [2:0]                       bus_addr,
  input logic [DATA_W-1:0]                bus_rdata,
  input logic                             glob_en,
  input logic                             user_en,
  input logic                             clr_cyc,
  input logic                             clr_evt,
  input logic [NUM_CNT-1:0]               cnt_wr,
  input logic [DATA_W-1:0]                cyc_val,
  input logic [NUM_CNT-1:0][DATA_W-1:0]   evt_val,
  input logic [NUM_CNT-1:0][EVT_W-1:0]    evt_type
);
  assert_cycle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_en && !clr_cyc) |=> $stable(cyc_val));

  assert_cycle_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cyc |=> (cyc_val == '0));

  assert_event_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> (evt_val == '0));

  assert_ctrl_selfclear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_addr == 3'd0) |-> (bus_rdata[2:1] == 2'b00));

  assert_unpriv_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && !bus_priv && !user_en) |-> (bus_rdata == '0));

  assert_user_bit_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_priv) |=> $stable(user_en));

  generate
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_chk
      assert_unsupported_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!SUPPORT_MAP[evt_type[g]] && !cnt_wr[g] && !clr_evt) |=> $stable(evt_val[g]));

      assert_single_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr[g] && !clr_evt) |=>
          ((evt_val[g] == $past(evt_val[g])) ||
           (evt_val[g] == $past(evt_val[g]) + DATA_W'(1))));
    end
  endgenerate
endmodule

bind perf_monitor_unit pmu_checker #(
  .DATA_W(DATA_W), .NUM_CNT(NUM_CNT), .NUM_EVT(NUM_EVT),
  .EVT_W(EVT_W), .SUPPORT_MAP(SUPPORT_MAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_priv(bus_priv), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .glob_en(glob_en), .user_en(user_en), .clr_cyc(clr_cyc),
  .clr_evt(clr_evt), .cnt_wr(cnt_wr), .cyc_val(cyc_val),
  .evt_val(evt_val), .evt_type(evt_type)
);

// File: tb/perf_monitor_unit_test.sv
module perf_monitor_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 5000;

  typedef struct packed {
    logic        we;
    logic        priv;
    logic [2:0]  addr;
    logic [31:0] wdata;
    logic        chk;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 3'd0, 32'h0,    1'b1, 32'h0,         8'd1},  // R1 control after reset
    '{1'b0, 1'b1, 3'd1, 32'h0,    1'b1, 32'h0,         8'd11}, // R11 enables after reset
    '{1'b1, 1'b0, 3'd2, 32'h2,    1'b0, 32'h0,         8'd7},  // R7 unpriv write dropped
    '{1'b0, 1'b1, 3'd2, 32'h0,    1'b1, 32'h0,         8'd7},
    '{1'b0, 1'b0, 3'd6, 32'h0,    1'b1, 32'h0,         8'd7},  // R7 unpriv read zero
    '{1'b1, 1'b0, 3'd7, 32'h1,    1'b0, 32'h0,         8'd8},  // R8 unpriv cannot set
    '{1'b0, 1'b1, 3'd7, 32'h0,    1'b1, 32'h0,         8'd8},
    '{1'b1, 1'b1, 3'd2, 32'h2,    1'b0, 32'h0,         8'd4},  // R4 select 2
    '{1'b0, 1'b1, 3'd2, 32'h0,    1'b1, 32'h2,         8'd4},
    '{1'b1, 1'b1, 3'd3, 32'h5,    1'b0, 32'h0,         8'd4},
    '{1'b0, 1'b1, 3'd3, 32'h0,    1'b1, 32'h5,         8'd4},
    '{1'b1, 1'b1, 3'd2, 32'h0,    1'b0, 32'h0,         8'd4},  // R4 other window
    '{1'b0, 1'b1, 3'd3, 32'h0,    1'b1, 32'h0,         8'd4},
    '{1'b1, 1'b1, 3'd2, 32'h2,    1'b0, 32'h0,         8'd4},
    '{1'b0, 1'b1, 3'd3, 32'h0,    1'b1, 32'h5,         8'd4},
    '{1'b0, 1'b1, 3'd6, 32'h0,    1'b1, 32'hFFFF_FF7F, 8'd6},  // R6 bitmap
    '{1'b1, 1'b1, 3'd6, 32'h0,    1'b0, 32'h0,         8'd6},  // R6 read-only
    '{1'b0, 1'b1, 3'd6, 32'h0,    1'b1, 32'hFFFF_FF7F, 8'd6},
    '{1'b1, 1'b1, 3'd0, 32'h6,    1'b0, 32'h0,         8'd3},  // R3 clears only
    '{1'b0, 1'b1, 3'd0, 32'h0,    1'b1, 32'h0,         8'd3},
    '{1'b1, 1'b1, 3'd2, 32'h6,    1'b0, 32'h0,         8'd9},  // R9 out of range
    '{1'b0, 1'b1, 3'd3, 32'h0,    1'b1, 32'h0,         8'd9},
    '{1'b1, 1'b1, 3'd3, 32'h9,    1'b0, 32'h0,         8'd9},
    '{1'b1, 1'b1, 3'd4, 32'h1234, 1'b0, 32'h0,         8'd9},
    '{1'b0, 1'b1, 3'd4, 32'h0,    1'b1, 32'h0,         8'd9},
    '{1'b0, 1'b1, 3'd2, 32'h0,    1'b1, 32'h6,         8'd9},
    '{1'b1, 1'b1, 3'd2, 32'h2,    1'b0, 32'h0,         8'd9},
    '{1'b0, 1'b1, 3'd3, 32'h0,    1'b1, 32'h5,         8'd9},
    '{1'b1, 1'b1, 3'd7, 32'h1,    1'b0, 32'h0,         8'd8},  // R8 priv sets
    '{1'b0, 1'b0, 3'd7, 32'h0,    1'b1, 32'h1,         8'd8},
    '{1'b1, 1'b0, 3'd2, 32'h1,    1'b0, 32'h0,         8'd7},  // R7 unpriv allowed
    '{1'b0, 1'b0, 3'd2, 32'h0,    1'b1, 32'h1,         8'd7},
    '{1'b1, 1'b0, 3'd7, 32'h0,    1'b0, 32'h0,         8'd8},
    '{1'b0, 1'b1, 3'd7, 32'h0,    1'b1, 32'h1,         8'd8},
    '{1'b1, 1'b1, 3'd5, 32'h37,   1'b0, 32'h0,         8'd2},  // R2 cycle read-only
    '{1'b0, 1'b1, 3'd5, 32'h0,    1'b1, 32'h0,         8'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0, bus_priv = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] event_strobe = '0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_monitor_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_priv(bus_priv), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .event_strobe(event_strobe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // One access: driven at the falling edge, read data sampled before the rising edge.
  task automatic bus_op(input logic we, input logic priv, input logic [2:0] addr,
                        input logic [31:0] wdata, output logic [31:0] rdata);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_priv = priv; bus_addr = addr; bus_wdata = wdata;
    #1 rdata = bus_rdata;
    @(posedge clk);
    #1 bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr(input logic [2:0] addr, input logic [31:0] d);
    logic [31:0] r;
    bus_op(1'b1, 1'b1, addr, d, r);
  endtask

  task automatic rd_chk(input string req, input logic [2:0] addr, input logic [31:0] exp);
    logic [31:0] r;
    bus_op(1'b0, 1'b1, addr, 32'h0, r);
    check(req, r, exp);
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      bus_op(VECS[i].we, VECS[i].priv, VECS[i].addr, VECS[i].wdata, r);
      if (VECS[i].chk) check($sformatf("R%0d vector %0d", VECS[i].req, i), r, VECS[i].exp);
    end

    // R10 R6 R1 R2: counter 0 on event 3, counter 1 on unimplemented event 7, counter 2 disabled
    wr(3'd2, 32'd0); wr(3'd3, 32'd3);
    wr(3'd2, 32'd1); wr(3'd3, 32'd7);
    wr(3'd2, 32'd2); wr(3'd3, 32'd3);
    wr(3'd1, 32'h3);
    wr(3'd0, 32'h7);                  // enable and clear both
    event_strobe = 32'h0000_0088;
    repeat (5) @(posedge clk);
    #1 event_strobe = '0;
    wr(3'd0, 32'h0);                  // cycle counted at this edge too
    rd_chk("R2 cycle total", 3'd5, 32'd6);
    wr(3'd2, 32'd0); rd_chk("R10 counter0 five strobes", 3'd4, 32'd5);
    wr(3'd2, 32'd1); rd_chk("R6 unimplemented event frozen", 3'd4, 32'd0);
    wr(3'd2, 32'd2); rd_chk("R10 disabled counter", 3'd4, 32'd0);

    // R1: strobes while globally disabled
    event_strobe = 32'h0000_0008;
    repeat (3) @(posedge clk);
    #1 event_strobe = '0;
    wr(3'd2, 32'd0); rd_chk("R1 disabled event count", 3'd4, 32'd5);
    rd_chk("R1 disabled cycle count", 3'd5, 32'd6);

    // R3: clear beats a simultaneous increment
    wr(3'd0, 32'h1);
    event_strobe = 32'h0000_0008;
    repeat (2) @(posedge clk);
    wr(3'd0, 32'h5);
    bus_op(1'b0, 1'b1, 3'd4, 32'h0, r);
    check("R3 event clear wins", r, 32'd0);
    #1 event_strobe = '0;
    wr(3'd0, 32'h3);
    bus_op(1'b0, 1'b1, 3'd5, 32'h0, r);
    check("R3 cycle clear", r, 32'd0);
    wr(3'd0, 32'h0);

    // R5: software write and wrap
    wr(3'd4, 32'hFFFF_FFFF);
    rd_chk("R5 value readback", 3'd4, 32'hFFFF_FFFF);
    wr(3'd0, 32'h1);
    event_strobe = 32'h0000_0008;
    @(posedge clk);
    #1 event_strobe = '0;
    wr(3'd0, 32'h0);
    rd_chk("R5 wrap to zero", 3'd4, 32'd0);
    rd_chk("R11 enable readback", 3'd0, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule